// File: doc/BRIEF.md
# Multi-Scheme Radix Page Table Walker

This block converts a virtual address into a physical address by reading page table entries from memory, one level at a time. It accepts a translation request made of the virtual address, the value of the address-translation control register and a flag that says whether the control register uses the 64-bit layout. The control register value selects one of three radix schemes: a two-level scheme with 4-byte entries, a three-level scheme with 8-byte entries, and a four-level scheme with 8-byte entries. The walk starts at the top level and moves down, issuing one entry read per level on a simple read master port.

Any level can end the walk with a leaf entry. A leaf at a level above the lowest is a superpage, and the lower virtual index fields then pass straight into the physical address. An invalid entry, a reserved write-without-read encoding, a memory error, a walk that runs past the lowest level without a leaf, or a control value with translation off or an unknown mode all end in a fault response. Only one translation is in flight at a time, and every port uses a valid/ready handshake.

Top module: `xw_page_walker`

## Requirements
- R1: `req_ready` is high only when no walk is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high. While a walk is running or its response is pending, the request port is ignored.
- R2: With `req_xlen64`=0, the mode is bit 31 of the control value and the root page number is bits 21:0. Mode 1 selects the two-level scheme. With `req_xlen64`=1, the mode is bits 63:60 and the root page number is bits 43:0. Mode 8 selects the three-level scheme and mode 9 selects the four-level scheme. All other control bits are ignored.
- R3: Translation off (mode 0) and any mode that is not supported give a fault response without any memory read.
- R4: The root table base is the root page number times 4096. Each entry address is the table base plus the level's index times the entry size. The entry size is 4 bytes for the two-level scheme and 8 bytes for the others, and `mem_req_wide` is 1 for 8-byte reads. In the two-level scheme the indices are 10 bits wide and start at virtual bits 12 and 22. In the other schemes they are 9 bits wide and start at bits 12, 21, 30 and 39. For 4-byte entries only `mem_rsp_data[31:0]` is used.
- R5: An entry with bit 0 (valid) clear, or with bit 2 (write) set while bit 1 (read) is clear, ends the walk at once with a fault. No further reads follow.
- R6: An entry with bit 1 (read) or bit 3 (execute) set is a leaf and ends the walk without a fault. The physical address is the virtual address with its page-number fields replaced, from the leaf level up to the top. Each field starts at address bit 12 + level times the index width. It takes the entry's page-number slice, which starts at entry bit 10 + level times the index width. The top slice is 12, 26 or 17 bits wide (two-, three-, four-level scheme) and the lower slices are as wide as the indices. Address bits outside the replaced fields pass through unchanged.
- R7: After a valid non-leaf entry, the next table base is the entry shifted right by 10 and then multiplied by 4096, and the walk goes down one level. A non-leaf entry at the lowest level gives a fault.
- R8: A read answered with `mem_rsp_err`=1 ends the walk with a fault.
- R9: Once `mem_req_valid` is raised, it stays high with a stable address until `mem_req_ready` takes it.
- R10: The response is held with stable `rsp_paddr` and `rsp_fault` until `rsp_ready`. `rsp_paddr` is 0 on a fault.
- R11: After reset, `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address to translate |
| req_ctrl | input | 64 | Address-translation control register value |
| req_xlen64 | input | 1 | 1: 64-bit control layout, 0: 32-bit layout |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_req_wide | output | 1 | 1: 8-byte entry, 0: 4-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry data |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 64 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Translation failed |

## Verification
Two events can fall in the same cycle: a new request arriving and the result of the current walk being handed back. The bench provokes this by keeping a decoy request valid on the request port for the whole walk, including the cycle in which the response handshake completes. It then judges that the decoy was never taken: `req_ready` stays low, the returned address matches the reference walk of the original request, and no extra reads appear. Memory stalls on both the read request and the read data overlap every walk, and each leaf level, fault kind and mode code is swept for all three schemes.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int XW_AW      = 64;
  localparam int XW_PGSH    = 12;
  localparam int XW_PPN_LSB = 10;
  localparam int XW_MAXLVL  = 4;
  localparam int XW_LVLW    = $clog2(XW_MAXLVL);

  typedef enum logic [1:0] {
    SCH_NONE = 2'd0,
    SCH_2LVL = 2'd1,
    SCH_3LVL = 2'd2,
    SCH_4LVL = 2'd3
  } xw_sch_e;

  typedef logic [XW_AW-1:0]   xw_addr_t;
  typedef logic [XW_LVLW-1:0] xw_lvl_t;

  function automatic int sch_levels(xw_sch_e s);
    case (s)
      SCH_2LVL: return 2;
      SCH_3LVL: return 3;
      SCH_4LVL: return 4;
      default:  return 1;
    endcase
  endfunction

  function automatic int sch_idx_w(xw_sch_e s);
    return (s == SCH_2LVL) ? 10 : 9;
  endfunction

  function automatic int sch_top_w(xw_sch_e s);
    case (s)
      SCH_2LVL: return 12;
      SCH_3LVL: return 26;
      SCH_4LVL: return 17;
      default:  return 0;
    endcase
  endfunction

  function automatic int sch_pte_exp(xw_sch_e s);
    return (s == SCH_2LVL) ? 2 : 3;
  endfunction

  // entry address: table base plus scaled index of the current level
  function automatic xw_addr_t pte_addr_of(xw_addr_t base, xw_addr_t va,
                                           xw_sch_e s, xw_lvl_t lvl);
    int iw;
    xw_addr_t idx;
    iw  = sch_idx_w(s);
    idx = (va >> (XW_PGSH + int'(lvl) * iw)) & ((xw_addr_t'(1) << iw) - 1'b1);
    return base + (idx << sch_pte_exp(s));
  endfunction

  // splice leaf page-number slices into the virtual address, leaf level upward
  function automatic xw_addr_t pa_compose(xw_addr_t va, xw_addr_t pte,
                                          xw_sch_e s, xw_lvl_t lvl);
    xw_addr_t pa;
    xw_addr_t m;
    int n;
    int iw;
    int w;
    pa = va;
    n  = sch_levels(s);
    iw = sch_idx_w(s);
    for (int i = 0; i < XW_MAXLVL; i++) begin
      if (i >= int'(lvl) && i < n) begin
        w  = (i == n - 1) ? sch_top_w(s) : iw;
        m  = (xw_addr_t'(1) << w) - 1'b1;
        pa = (pa & ~(m << (XW_PGSH + i * iw))) |
             (((pte >> (XW_PPN_LSB + i * iw)) & m) << (XW_PGSH + i * iw));
      end
    end
    return pa;
  endfunction
endpackage

// File: rtl/xw_mode_decode.sv
module xw_mode_decode
  import xw_pkg::*;
#(
  parameter int MODE32_BIT = 31,
  parameter int PPN32_W    = 22,
  parameter int MODE64_LSB = 60,
  parameter int MODE64_W   = 4,
  parameter int PPN64_W    = 44,
  parameter int CODE_2LVL  = 1,
  parameter int CODE_3LVL  = 8,
  parameter int CODE_4LVL  = 9
) (
  input  logic [XW_AW-1:0] ctrl,
  input  logic             xlen64,
  output xw_sch_e          sch,
  output xw_addr_t         root
);
  logic [MODE64_W-1:0] mode64;
  logic                unused_ctrl_bits;

  assign mode64           = ctrl[MODE64_LSB +: MODE64_W];
  assign unused_ctrl_bits = ^ctrl[MODE64_LSB-1:PPN64_W];

  always_comb begin
    sch  = SCH_NONE;
    root = '0;
    if (!xlen64) begin
      if (ctrl[MODE32_BIT] == 1'(CODE_2LVL)) sch = SCH_2LVL;
      root = xw_addr_t'(ctrl[PPN32_W-1:0]) << XW_PGSH;
    end else begin
      if (mode64 == MODE64_W'(CODE_3LVL))      sch = SCH_3LVL;
      else if (mode64 == MODE64_W'(CODE_4LVL)) sch = SCH_4LVL;
      root = xw_addr_t'(ctrl[PPN64_W-1:0]) << XW_PGSH;
    end
  end
endmodule

// File: rtl/xw_pte_check.sv
module xw_pte_check
  import xw_pkg::*;
#(
  parameter int NARROW_W = 32,
  parameter int V_BIT    = 0,
  parameter int R_BIT    = 1,
  parameter int W_BIT    = 2,
  parameter int X_BIT    = 3
) (
  input  logic [XW_AW-1:0] data,
  input  xw_sch_e          sch,
  output xw_addr_t         pte,
  output logic             is_bad,
  output logic             is_leaf,
  output xw_addr_t         nxt_base
);
  assign pte      = (sch == SCH_2LVL) ? xw_addr_t'(data[NARROW_W-1:0]) : data;
  assign is_bad   = !pte[V_BIT] || (pte[W_BIT] && !pte[R_BIT]);
  assign is_leaf  = pte[R_BIT] || pte[X_BIT];
  assign nxt_base = (pte >> XW_PPN_LSB) << XW_PGSH;
endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
(
  input  xw_addr_t base,
  input  xw_addr_t va,
  input  xw_sch_e  sch,
  input  xw_lvl_t  lvl,
  output xw_addr_t addr,
  output logic     wide
);
  assign addr = pte_addr_of(base, va, sch, lvl);
  assign wide = (sch_pte_exp(sch) == 3);
endmodule

// File: rtl/xw_page_walker.sv
module xw_page_walker
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [XW_AW-1:0] req_vaddr,
  input  logic [XW_AW-1:0] req_ctrl,
  input  logic             req_xlen64,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XW_AW-1:0] mem_req_addr,
  output logic             mem_req_wide,
  input  logic             mem_rsp_valid,
  input  logic [XW_AW-1:0] mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [XW_AW-1:0] rsp_paddr,
  output logic             rsp_fault
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

  st_e      st_q;
  xw_sch_e  sch_q;
  xw_lvl_t  lvl_q;
  xw_addr_t base_q, va_q, paddr_q;
  logic     fault_q;

  xw_sch_e  dec_sch;
  xw_addr_t dec_root;
  xw_addr_t chk_pte, chk_next;
  logic     chk_bad, chk_leaf;

  // named events for the assertions
  logic req_fire, acc_bad_mode, pte_take, leaf_ev, walk_fault_ev;

  xw_mode_decode u_dec (
    .ctrl   (req_ctrl),
    .xlen64 (req_xlen64),
    .sch    (dec_sch),
    .root   (dec_root)
  );

  xw_pte_check u_chk (
    .data     (mem_rsp_data),
    .sch      (sch_q),
    .pte      (chk_pte),
    .is_bad   (chk_bad),
    .is_leaf  (chk_leaf),
    .nxt_base (chk_next)
  );

  xw_addr_gen u_agen (
    .base (base_q),
    .va   (va_q),
    .sch  (sch_q),
    .lvl  (lvl_q),
    .addr (mem_req_addr),
    .wide (mem_req_wide)
  );

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign rsp_valid     = (st_q == ST_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;

  assign req_fire      = req_valid && req_ready;
  assign acc_bad_mode  = (dec_sch == SCH_NONE);
  assign pte_take      = (st_q == ST_WAIT) && mem_rsp_valid;
  assign leaf_ev       = pte_take && !mem_rsp_err && !chk_bad && chk_leaf;
  assign walk_fault_ev = pte_take && (mem_rsp_err || chk_bad ||
                                      (!chk_leaf && lvl_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sch_q   <= SCH_NONE;
      lvl_q   <= '0;
      base_q  <= '0;
      va_q    <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_fire) begin
          va_q   <= req_vaddr;
          sch_q  <= dec_sch;
          base_q <= dec_root;
          lvl_q  <= xw_lvl_t'(sch_levels(dec_sch) - 1);
          if (acc_bad_mode) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            st_q    <= ST_DONE;
          end else begin
            st_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err || chk_bad) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            st_q    <= ST_DONE;
          end else if (chk_leaf) begin
            fault_q <= 1'b0;
            paddr_q <= pa_compose(va_q, chk_pte, sch_q, lvl_q);
            st_q    <= ST_DONE;
          end else if (lvl_q == '0) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            st_q    <= ST_DONE;
          end else begin
            lvl_q  <= lvl_q - 1'b1;
            base_q <= chk_next;
            st_q   <= ST_ISSUE;
          end
        end
        ST_DONE: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1: a taken request closes the request port on the next cycle
  a_r1_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R3: off or unknown mode answers with a fault and issues no read
  a_r3_bad_mode_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && acc_bad_mode |=> rsp_valid && rsp_fault && !mem_req_valid);

  // R4: entry addresses are aligned to the entry size
  a_r4_pte_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_wide ? (mem_req_addr[2:0] == 3'b0)
                                    : (mem_req_addr[1:0] == 2'b0)));

  // R5 R7 R8: a faulting entry, error or missing leaf ends the walk with a fault
  a_r5_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault_ev |=> rsp_valid && rsp_fault && !mem_req_valid);

  // R8: a memory error is never turned into a translation
  a_r8_err_faults: assert property (@(posedge clk) disable iff (!rst_n)
    pte_take && mem_rsp_err |=> rsp_fault);

  // R6: a leaf ends the walk with a good result
  a_r6_leaf_ok: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_ev |=> rsp_valid && !rsp_fault);

  // R9: a read request is held until taken
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10: the result is held until taken
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));
endmodule

// File: tb/xw_page_walker_tb_top.sv
`timescale 1ns/1ps
module xw_page_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [63:0] req_ctrl = '0;
  logic        req_xlen64 = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_req_wide;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_paddr;
  logic        rsp_fault;

  int total = 0;
  int bad = 0;

  logic [63:0] pmem [logic [63:0]];
  bit          errmap [logic [63:0]];

  int          reads = 0;
  int          wide_bad = 0;
  int          r9_bad = 0;
  bit          exp_wide = 1'b0;
  logic [63:0] last_pa;
  bit          last_fault;

  always #2.5 clk = ~clk;

  xw_page_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_ctrl(req_ctrl), .req_xlen64(req_xlen64),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: random stalls on both channels
  initial begin : memory_model
    bit          pend = 1'b0;
    logic [63:0] pa_addr = '0;
    int          dly = 0;
    bit          stalled = 1'b0;
    logic [63:0] st_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          logic [63:0] v;
          v = pmem.exists(pa_addr) ? pmem[pa_addr] : 64'h0;
          mem_rsp_valid = 1'b1;
          mem_rsp_err   = errmap.exists(pa_addr);
          mem_rsp_data  = exp_wide ? v : {~pa_addr[31:0], v[31:0]};
          pend = 1'b0;
        end else dly--;
      end
      if (stalled && !(mem_req_valid && mem_req_addr == st_addr)) r9_bad++;
      mem_req_ready = ($urandom % 4) != 0;
      stalled = mem_req_valid && !mem_req_ready;
      st_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        pa_addr = mem_req_addr;
        dly = $urandom % 3;
        reads++;
        if (mem_req_wide != exp_wide) wide_bad++;
      end
    end
  end

  // independent reference of the walk
  function automatic void ref_walk(input logic [63:0] va, input logic [63:0] ctrl,
                                   input bit x64, output bit flt,
                                   output logic [63:0] pa, output int nrd,
                                   output bit wide);
    int nl = 0, iw = 0, tw = 0, lo, hi;
    bit ok_mode = 0, done = 0;
    logic [63:0] tbl, a, pte, m_lo, m_hi;
    flt = 1; pa = 0; nrd = 0;
    if (!x64) begin
      if (ctrl[31]) begin nl = 2; iw = 10; tw = 12; ok_mode = 1; end
      tbl = {42'b0, ctrl[21:0]} * 64'd4096;
      wide = 0;
    end else begin
      if (ctrl[63:60] == 4'd8) begin nl = 3; iw = 9; tw = 26; ok_mode = 1; end
      if (ctrl[63:60] == 4'd9) begin nl = 4; iw = 9; tw = 17; ok_mode = 1; end
      tbl = {20'b0, ctrl[43:0]} * 64'd4096;
      wide = 1;
    end
    if (!ok_mode) return;
    for (int l = nl - 1; l >= 0 && !done; l--) begin
      a = tbl + (((va >> (12 + iw * l)) % (64'd1 << iw)) * (wide ? 64'd8 : 64'd4));
      nrd++;
      pte = pmem.exists(a) ? pmem[a] : 64'h0;
      if (!wide) pte = pte & 64'hFFFF_FFFF;
      if (errmap.exists(a)) done = 1;
      else if (!pte[0] || (pte[2] && !pte[1])) done = 1;
      else if (pte[1] || pte[3]) begin
        lo   = 12 + iw * l;
        hi   = 12 + iw * (nl - 1) + tw;
        m_lo = (64'd1 << lo) - 1;
        m_hi = (64'd1 << hi) - 1;
        pa   = (va & ~m_hi) | ((((pte >> 10) >> (iw * l)) << lo) & m_hi & ~m_lo) |
               (va & m_lo);
        flt  = 0;
        done = 1;
      end else tbl = (pte >> 10) * 64'd4096;
    end
  endfunction

  task automatic run_walk(input logic [63:0] va, input logic [63:0] ctrl,
                          input bit x64, input string tag);
    bit e_flt, e_wide;
    logic [63:0] e_pa, h_pa;
    int e_rd, cyc, r1_bad, hold;
    bit h_flt, r10_ok;
    ref_walk(va, ctrl, x64, e_flt, e_pa, e_rd, e_wide);
    @(negedge clk);
    exp_wide = e_wide; reads = 0; wide_bad = 0; r9_bad = 0; r1_bad = 0;
    req_vaddr = va; req_ctrl = ctrl; req_xlen64 = x64; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(!req_ready, "R1", {tag, " port closed after accept"}, 64'(req_ready), 64'd0);
    // decoy request held on the port for the whole walk
    req_vaddr = ~va; req_ctrl = ~ctrl;
    cyc = 0;
    while (!rsp_valid && cyc < 2000) begin
      @(negedge clk);
      if (req_ready) r1_bad++;
      cyc++;
    end
    chk(r1_bad == 0, "R1", {tag, " decoy ignored"}, 64'(r1_bad), 64'd0);
    h_pa = rsp_paddr; h_flt = rsp_fault; r10_ok = 1;
    hold = $urandom % 3;
    repeat (hold) begin
      @(negedge clk);
      if (!rsp_valid || rsp_paddr != h_pa || rsp_fault != h_flt) r10_ok = 0;
    end
    chk(r10_ok, "R10", {tag, " result held"}, rsp_paddr, h_pa);
    chk(rsp_fault == e_flt, "R5", {tag, " fault flag"}, 64'(rsp_fault), 64'(e_flt));
    chk(rsp_paddr == e_pa, "R6", {tag, " physical address"}, rsp_paddr, e_pa);
    chk(reads == e_rd, "R4", {tag, " read count"}, 64'(reads), 64'(e_rd));
    chk(wide_bad == 0, "R4", {tag, " entry size flag"}, 64'(wide_bad), 64'd0);
    chk(r9_bad == 0, "R9", {tag, " read request held"}, 64'(r9_bad), 64'd0);
    last_pa = rsp_paddr; last_fault = rsp_fault;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b0;
  endtask

  // fk: 0 none, 1 invalid, 2 write-only, 3 memory error, 4 no leaf
  task automatic build(input int sch, input logic [63:0] va, input int leaf_l,
                       input int fk, input int fl, output logic [63:0] ctrl);
    int nl, iw, esz, l;
    bit done;
    logic [63:0] root, tp, a, pte, nxt;
    logic [4:0] flags [5];
    flags = '{5'h03, 5'h09, 5'h07, 5'h0B, 5'h0F};
    nl  = (sch == 0) ? 2 : (sch == 1) ? 3 : 4;
    iw  = (sch == 0) ? 10 : 9;
    esz = (sch == 0) ? 4 : 8;
    pmem.delete(); errmap.delete();
    root = 64'h40 + 64'($urandom % 16);
    tp = root; done = 0;
    for (l = nl - 1; l >= 0 && !done; l--) begin
      a = tp * 4096 + ((va >> (12 + iw * l)) & ((64'd1 << iw) - 1)) * 64'(esz);
      if (fk != 0 && fk != 4 && l == fl) begin
        if (fk == 1) pte = {$urandom, $urandom} & ~64'h1;
        else if (fk == 2) pte = (64'($urandom) << 10) | 64'h5;
        else begin pte = 64'h3; errmap[a] = 1; end
        pmem[a] = pte; done = 1;
      end else if (l == leaf_l) begin
        pte = ({$urandom, $urandom} << 10) | 64'(flags[$urandom % 5]) |
              (64'($urandom % 4) << 6);
        pmem[a] = pte; done = 1;
      end else begin
        nxt = 64'h100 * 64'(l + 1) + 64'($urandom % 16);
        pmem[a] = (nxt << 10) | 64'h1;
        tp = nxt;
      end
    end
    if (sch == 0) ctrl = {$urandom, 1'b1, 9'($urandom), 22'(root)};
    else ctrl = {(sch == 1) ? 4'd8 : 4'd9, 16'($urandom), 44'(root)};
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog: actual=%h expected=%h", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] ctrl, va;
    int nl;
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !rsp_valid, "R11", "outputs idle in reset",
        {62'b0, mem_req_valid, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", 64'(req_ready), 64'd1);
    chk(!mem_req_valid && !rsp_valid, "R11", "no activity after reset",
        {62'b0, mem_req_valid, rsp_valid}, 64'd0);

    // directed superpage in the two-level scheme
    pmem.delete(); errmap.delete();
    pmem[64'h5004] = 64'h2AF0_0003;
    run_walk(64'h0040_3ABC, 64'h8000_0005, 1'b0, "two-level superpage");
    chk(last_pa == 64'hABC0_3ABC && !last_fault, "R6", "directed superpage",
        last_pa, 64'hABC0_3ABC);

    // mode code sweep, 64-bit layout, empty memory (R2 R3)
    for (int m = 0; m < 16; m++) begin
      pmem.delete(); errmap.delete();
      run_walk(64'h1234_5678_9000, {4'(m), 16'hBEEF, 44'h40}, 1'b1, "R3 mode sweep");
    end
    // layout depends on the xlen flag (R2)
    run_walk(64'h1000, 64'h8000_0000_0000_0040, 1'b0, "R2 xlen32 ignores upper mode");
    chk(last_fault == 1'b1 && reads == 0, "R3", "no reads on off mode",
        64'(reads), 64'd0);
    run_walk(64'h1000, 64'h0000_0000_8000_0040, 1'b1, "R2 xlen64 ignores bit 31");
    chk(last_fault == 1'b1 && reads == 0, "R2", "no reads under layout mismatch",
        64'(reads), 64'd0);

    // leaf at every level of every scheme (R4 R6 R7)
    for (int s = 0; s < 3; s++) begin
      nl = (s == 0) ? 2 : (s == 1) ? 3 : 4;
      for (int ll = 0; ll < nl; ll++) begin
        for (int k = 0; k < 6; k++) begin
          va = (s == 0) ? 64'($urandom) : {$urandom, $urandom};
          build(s, va, ll, 0, 0, ctrl);
          run_walk(va, ctrl, s != 0, "R7 leaf sweep");
        end
      end
    end

    // faults at every level (R5 R8) and missing leaf (R7)
    for (int s = 0; s < 3; s++) begin
      nl = (s == 0) ? 2 : (s == 1) ? 3 : 4;
      for (int fl = 0; fl < nl; fl++) begin
        for (int fk = 1; fk <= 3; fk++) begin
          va = {$urandom, $urandom};
          if (s == 0) va = va & 64'hFFFF_FFFF;
          build(s, va, -1, fk, fl, ctrl);
          run_walk(va, ctrl, s != 0, (fk == 3) ? "R8 memory error" : "R5 bad entry");
          chk(last_fault == 1'b1, (fk == 3) ? "R8" : "R5", "fault raised",
              64'(last_fault), 64'd1);
          chk(reads == nl - fl, "R5", "walk stops at fault", 64'(reads), 64'(nl - fl));
        end
      end
      va = {$urandom, $urandom};
      build(s, va, -1, 4, 0, ctrl);
      run_walk(va, ctrl, s != 0, "R7 no leaf");
      chk(last_fault == 1'b1 && last_pa == 64'd0, "R7", "no leaf faults",
          last_pa, 64'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule